// File: doc/BRIEF.md
# Byte-Programmed 16-bit Down-Timer

This block is a 16-bit down-counting timer that software sets up through a small byte-wide register bus. A control byte selects the count source, chooses between one-shot and continuous operation, and starts or stops the count. The 16-bit reload value is written as two separate bytes. The count source is either every system clock or a slow tick enable. The slow tick is a synchronous single-cycle enable derived from a 32 kHz source, so the whole block runs in one clock domain.

Setting the start bit loads the counter with the full reload value. The counter then steps down by one on each enabled tick. An enabled tick that finds the counter at zero ends the cycle and produces a one-clock terminal pulse. What happens next depends on the mode. In continuous mode the counter reloads and keeps going. In one-shot mode the counter stops and hardware clears the start bit, so software can poll that bit to learn that the timer has expired.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, all control and reload bits are 0, the counter is 0, the terminal pulse is low and every register reads 0.
- R2: Register addresses: 0 is the control byte, 1 is the reload low byte, 2 is the reload high byte, and 3 reads 0. In the control byte, bit 2 selects the fast source, bit 1 selects one-shot mode, bit 0 is start, and bits 7..3 read 0. Written values read back, and the control byte shows the live start bit.
- R3: A write with bit 0 = 1 while stopped loads the counter with {high byte, low byte} at that clock edge.
- R4: With bit 2 = 1 the counter advances on every clock. With bit 2 = 0 it advances only in cycles where slowTick is 1.
- R5: Each enabled tick decrements a non-zero counter by one. An enabled tick at zero ends the cycle and drives termPulse high for the next clock only.
- R6: In one-shot mode, the end of a cycle clears start, leaves the counter at 0 and stops further ticks.
- R7: In continuous mode, the end of a cycle reloads {high, low}, so a reload value N gives one pulse every N+1 enabled ticks.
- R8: Writing start = 0 stops the count at once and holds the counter. Writing start = 1 while the timer runs does not reload the counter.
- R9: A reload-byte write while the timer runs leaves the counter alone. The new value is used from the next reload or start.
- R10: A reload value of 0 gives a terminal pulse on every enabled tick in continuous mode.
- R11: A control write in the same cycle as a one-shot end takes priority, so a start bit written as 1 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slowTick | input | 1 | Synchronous slow count enable, one clock wide |
| regAddr | input | 2 | Register address |
| regWe | input | 1 | Write enable, one write per cycle |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for regAddr |
| termPulse | output | 1 | One-clock end-of-cycle pulse |
| countNow | output | 16 | Current counter value |

## Verification
The assertions assume that slowTick is already synchronous to clk and that only one register write arrives per cycle. They also assume that reset is applied before the first use. The bench drives every input just after a falling edge, so each input is stable across the following rising edge. Its stimulus mixes directed sequences with random writes to random addresses and a random slow-tick pattern, and it never violates these assumptions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_LO  = 2'd1;
  localparam logic [1:0] ADDR_HI  = 2'd2;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic loadCnt;
    logic decCnt;
    logic reloadCnt;
    logic endCycle;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [1:0]        regAddr,
  input  logic              regWe,
  input  logic [2:0]        cfgWdata,
  input  logic              cntZero,
  output tmrStrobe_t        strb,
  output logic [DATA_W-1:0] cfgByte
);
  logic fastSel, oneShot, runBit;
  logic cfgWr, startRise, stopReq, tickEn, active;

  assign cfgWr     = regWe && (regAddr == ADDR_CFG);
  assign startRise = cfgWr && cfgWdata[0] && !runBit;
  assign stopReq   = cfgWr && !cfgWdata[0];
  assign tickEn    = fastSel | slowTick;
  assign active    = runBit && !stopReq && tickEn;

  always_comb begin
    strb           = '0;
    strb.wrLo      = regWe && (regAddr == ADDR_LO);
    strb.wrHi      = regWe && (regAddr == ADDR_HI);
    strb.loadCnt   = startRise;
    strb.decCnt    = active && !cntZero;
    strb.endCycle  = active && cntZero;
    strb.reloadCnt = active && cntZero && !oneShot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastSel <= 1'b0;
      oneShot <= 1'b0;
      runBit  <= 1'b0;
    end else if (cfgWr) begin
      fastSel <= cfgWdata[2];
      oneShot <= cfgWdata[1];
      runBit  <= cfgWdata[0];
    end else if (strb.endCycle && oneShot) begin
      runBit  <= 1'b0;
    end
  end

  assign cfgByte = {{(DATA_W-3){1'b0}}, fastSel, oneShot, runBit};

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.endCycle && oneShot && !cfgWr) |=> !runBit);

  // R8
  stop_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !runBit);

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgWdata[0]) |=> runBit);

  // R4
  slow_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fastSel && !slowTick) |-> !(strb.decCnt || strb.endCycle));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [CNT_W-1:0]  count,
  output logic              cntZero,
  output logic              termPulse
);
  logic [DATA_W-1:0] loByte, hiByte;

  assign reloadVal = {hiByte, loByte};
  assign cntZero   = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte <= '0;
      hiByte <= '0;
    end else begin
      if (strb.wrLo) loByte <= wrData;
      if (strb.wrHi) hiByte <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      termPulse <= 1'b0;
    end else begin
      termPulse <= strb.endCycle;
      if (strb.loadCnt || strb.reloadCnt) count <= reloadVal;
      else if (strb.decCnt)               count <= count - 1'b1;
    end
  end

  // R5
  term_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    termPulse |-> ($past(count) == '0));

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (count == $past(reloadVal)));

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCnt |=> (count == $past(count) - 1'b1));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadCnt || strb.decCnt || strb.reloadCnt) |=> $stable(count));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadCnt, strb.decCnt, strb.endCycle}));
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [1:0]        regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              termPulse,
  output logic [CNT_W-1:0]  countNow
);
  tmrStrobe_t        strb;
  logic [DATA_W-1:0] cfgByte;
  logic [CNT_W-1:0]  reloadVal;
  logic              cntZero;

  tmr_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .slowTick (slowTick),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .cfgWdata (regWdata[2:0]),
    .cntZero  (cntZero),
    .strb     (strb),
    .cfgByte  (cfgByte)
  );

  tmr_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (regWdata),
    .reloadVal (reloadVal),
    .count     (countNow),
    .cntZero   (cntZero),
    .termPulse (termPulse)
  );

  always_comb begin
    case (regAddr)
      ADDR_CFG: regRdata = cfgByte;
      ADDR_LO:  regRdata = reloadVal[DATA_W-1:0];
      ADDR_HI:  regRdata = reloadVal[CNT_W-1:DATA_W];
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: tb/tick_down_timer_tb_top.sv
`timescale 1ns/1ps
module tick_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWe = 1'b0;
  logic [7:0]  regWdata = 8'd0;
  logic [7:0]  regRdata;
  logic        termPulse;
  logic [15:0] countNow;

  int nChk = 0;
  int nBad = 0;
  int pulses;
  int held;

  // behavioural reference state
  int mFast = 0, mOne = 0, mRun = 0, mLo = 0, mHi = 0, mCnt = 0, mTc = 0;

  always #10 clk = ~clk;

  tick_down_timer dut_i (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .termPulse(termPulse), .countNow(countNow)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mFast = 0; mOne = 0; mRun = 0; mLo = 0; mHi = 0; mCnt = 0; mTc = 0;
    end else begin
      bit cfgW, tick;
      int nTc;
      cfgW = regWe && (regAddr == 2'd0);
      tick = (mFast != 0) || slowTick;
      nTc  = 0;
      if (cfgW && regWdata[0] && mRun == 0) begin
        mCnt = mHi * 256 + mLo;
      end else if (mRun != 0 && !(cfgW && !regWdata[0]) && tick) begin
        if (mCnt == 0) begin
          nTc = 1;
          if (mOne != 0) mRun = 0;
          else mCnt = mHi * 256 + mLo;
        end else begin
          mCnt = mCnt - 1;
        end
      end
      mTc = nTc;
      if (cfgW) begin
        mFast = regWdata[2]; mOne = regWdata[1]; mRun = regWdata[0];
      end
      if (regWe && regAddr == 2'd1) mLo = regWdata;
      if (regWe && regAddr == 2'd2) mHi = regWdata;
    end
  end

  function automatic int modelRd();
    case (regAddr)
      2'd0:    return mFast * 4 + mOne * 2 + mRun;
      2'd1:    return mLo;
      2'd2:    return mHi;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R2 regRdata vs model", regRdata, modelRd());
    check("R5 termPulse vs model", termPulse, mTc);
    check("R5 countNow vs model", countNow, mCnt);
    pulses += termPulse;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    regAddr = a; regWe = 1'b1; regWdata = d;
    step();
    regWe = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    pulses = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R1
    check("R1 cfg after reset", regRdata, 0);
    check("R1 count after reset", countNow, 0);
    check("R1 pulse after reset", termPulse, 0);

    // one-shot, fast source, reload 3
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd0);
    regAddr = 2'd1; step();
    check("R2 low byte readback", regRdata, 3);
    wr(2'd0, 8'h07);
    check("R3 load on start", countNow, 3);
    pulses = 0;
    idle(8);
    check("R6 single pulse", pulses, 1);
    check("R6 start cleared", regRdata, 6);
    check("R6 counter held at zero", countNow, 0);
    regAddr = 2'd3; step();
    check("R2 unmapped reads zero", regRdata, 0);
    wr(2'd0, 8'hFE);
    check("R2 upper cfg bits read zero", regRdata, 6);

    // continuous, fast, reload 2
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h05);
    idle(5);
    pulses = 0;
    idle(30);
    check("R7 period of N+1", pulses, 10);

    // reload 0
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h05);
    idle(2);
    pulses = 0;
    idle(10);
    check("R10 pulse every tick", pulses, 10);

    // stop holds count
    wr(2'd1, 8'd200);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h05);
    idle(7);
    wr(2'd0, 8'h00);
    held = countNow;
    idle(5);
    check("R8 stop holds count", countNow, held);
    check("R8 start reads zero", regRdata, 0);

    // slow source
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h01);
    check("R3 load on slow start", countNow, 5);
    idle(10);
    check("R4 no tick without slowTick", countNow, 5);
    slowTick = 1'b1; step(); slowTick = 1'b0;
    check("R4 one slow tick", countNow, 4);
    wr(2'd0, 8'h01);
    check("R8 restart while running no reload", countNow, 4);
    wr(2'd1, 8'd9);
    check("R9 data write no effect on count", countNow, 4);
    slowTick = 1'b1;
    idle(4);
    check("R5 reached zero", countNow, 0);
    step();
    slowTick = 1'b0;
    check("R9 new reload used", countNow, 9);
    check("R5 terminal pulse", termPulse, 1);
    step();
    check("R5 pulse one clock", termPulse, 0);

    // write priority at one-shot end
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h07);
    check("R3 load 1", countNow, 1);
    step();
    check("R5 decrement to zero", countNow, 0);
    wr(2'd0, 8'h07);
    check("R5 pulse at end", termPulse, 1);
    check("R11 write keeps start", regRdata, 7);
    step();
    check("R6 start cleared next end", regRdata, 6);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      slowTick = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) begin
        regAddr = 2'($urandom_range(0, 3));
        regWe = 1'b1;
        regWdata = (regAddr == 2'd0) ? 8'($urandom_range(0, 255))
                                     : 8'($urandom_range(0, 12));
      end else begin
        regWe = 1'b0;
        regAddr = 2'($urandom_range(0, 3));
      end
      step();
    end
    regWe = 1'b0;
    finishRun();
  end
endmodule